// File: doc/BRIEF.md
# Eight-Lane ADC Word Aligner and Deserializer

This block takes the serial output of a fast analog-to-digital converter that spreads its samples over eight data lanes, each carrying one bit on every edge of a shared bit clock, plus a ninth line that marks where each sample starts. Every lane is collected into 8-bit words, one word every four bit-clock cycles. The marker line is collected the same way. Its word is compared against the expected boundary pattern. If it does not match, the word boundary of all nine lanes is moved by one bit at a time until the words line up with whole samples.

Once the marker has matched for a run of word periods, the block flags lock. It then emits one 64-bit word per word period, with lane 0 in the low byte, together with a one-cycle qualifier. The divided rate is carried as a one-in-four enable inside the bit-clock domain, so the output and its qualifier are registered on the bit clock. A downstream buffer samples the word when the qualifier is high.

Top module: `adc_frame_deser`

## Requirements
- R1: Each lane is sampled on both edges of `clk_bit`; within each cycle the falling-edge bit is older than the following rising-edge bit. Samples are sent most significant bit first. `word_valid_o` is never high on two consecutive cycles, and one word is produced every 4 cycles of `clk_bit`.
- R2: `word_o[8*i+7:8*i]` carries the sample from lane i, so lane 0 is at bits [7:0] and lane 7 at bits [63:56].
- R3: The marker line must read 1,1,1,1,0,0,0,0 in arrival order over one sample, i.e. the captured marker word equals 8'hF0 with the first-arriving bit as the MSB. A mismatching marker word moves the boundary of all lanes by exactly one bit. The boundary does not move in any other case.
- R4: After a boundary move, no further move happens during the next 4 word periods.
- R5: `aligned_o` rises only after 16 consecutive word periods with a matching marker, so it stays low for at least 64 cycles after reset.
- R6: Any marker mismatch clears `aligned_o` at the end of that word period.
- R7: `word_valid_o` is high only while `aligned_o` is high. Once the block is locked on a clean stream, successive valid words carry consecutive samples, with none missing or repeated.
- R8: Synchronous active-low `rst_n` clears `aligned_o`, `word_valid_o` and the boundary position.
- R9: From any starting bit offset, and again after a disturbance of the marker, `aligned_o` is reached within 320 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; data valid on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_ser_i | input | 8 | Serial data, one bit per lane |
| frame_ser_i | input | 1 | Serial sample-boundary marker |
| word_o | output | 64 | Aligned parallel word, lane 0 in the low byte |
| word_valid_o | output | 1 | One-cycle qualifier for `word_o` |
| aligned_o | output | 1 | Boundary lock achieved |

## Verification
The hardest situation to reach is a full relock: the block is already locked, a marker mismatch knocks it off the correct boundary, it walks the whole slip cycle back round with the settle gaps in between, and the data stream must then resume with no lost or repeated samples. The bench drives a triangle ramp on all lanes starting at every possible bit offset, plus some random ones. In two runs it blanks eight marker bits while the block is locked. Its scoreboard resynchronises to the sample queue and continues to check every word for sample continuity.

// File: rtl/adc_deser_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the lane deserializer.
package adc_deser_pkg;
    localparam int unsigned DEF_LANES     = 8;     // data lanes
    localparam int unsigned DEF_BITS      = 8;     // bits per sample
    localparam logic [7:0]  DEF_FRAME_PAT = 8'hF0; // marker word, first bit in MSB
    localparam int unsigned DEF_SETTLE    = 4;     // word periods after a slip
    localparam int unsigned DEF_LOCK      = 16;    // matches needed for lock
endpackage

// File: rtl/adc_lane_gearbox.sv
`timescale 1ns/1ps
// adc_lane_gearbox
// Collects one double-data-rate serial lane into a bit history and exposes
// a W-bit window at a selectable bit offset. The oldest bit in the window
// is its MSB.
// Assumes: W is even (two bits enter per clock cycle) and offsets below W.
module adc_lane_gearbox #(
    parameter int unsigned W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_i,
    input  logic [$clog2(W)-1:0] ofs_i,
    output logic [W-1:0]         word_o
);
    localparam int unsigned HIST_W = 2 * W;

    logic              fall_q;
    logic [HIST_W-1:0] hist_q;

    // Capture the falling-edge bit of each cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= ser_i;
    end

    // Shift in the falling-edge bit then the rising-edge bit, newest at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_W-3:0], fall_q, ser_i};
    end

    // Select the window at the current boundary offset.
    always_comb word_o = hist_q[ofs_i +: W];

    // R1: two bits enter per cycle, the falling-edge one ahead of the rising one.
    assert_ddr_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hist_q[1:0] == {$past(fall_q), $past(ser_i)}));
endmodule

// File: rtl/adc_frame_aligner.sv
`timescale 1ns/1ps
// adc_frame_aligner
// Generates the one-in-W/2 word strobe, compares the captured marker word
// with the expected pattern, slips the shared boundary offset by one bit on
// a mismatch (with a settle gap), and counts consecutive matches for lock.
// Assumes: W is a power of two, at least 4; LOCK_CNT >= 1.
module adc_frame_aligner #(
    parameter int unsigned W        = 8,
    parameter logic [W-1:0] PAT     = 8'hF0,
    parameter int unsigned SETTLE   = 4,
    parameter int unsigned LOCK_CNT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         frame_word_i,
    output logic                 stb_o,
    output logic [$clog2(W)-1:0] ofs_o,
    output logic                 aligned_o,
    output logic                 accept_o
);
    localparam int unsigned PH_W   = $clog2(W / 2);
    localparam int unsigned OFS_W  = $clog2(W);
    localparam int unsigned HOLD_W = $clog2(SETTLE + 1);
    localparam int unsigned CNT_W  = $clog2(LOCK_CNT + 1);

    logic [PH_W-1:0]   phase_q;
    logic [HOLD_W-1:0] hold_q;
    logic [CNT_W-1:0]  match_cnt_q;
    logic              match;
    logic              slip;

    // Word strobe on the last cycle of each word period.
    always_comb stb_o = (phase_q == PH_W'(W / 2 - 1));
    // Marker comparison and slip decision.
    always_comb match = (frame_word_i == PAT);
    always_comb slip  = stb_o && !match && (hold_q == '0);

    // Count bit-clock cycles within one word period.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    // Move the boundary on a slip and load the settle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_o  <= '0;
            hold_q <= '0;
        end else if (slip) begin
            ofs_o  <= (ofs_o == OFS_W'(W - 1)) ? '0 : ofs_o + 1'b1;
            hold_q <= HOLD_W'(SETTLE);
        end else if (stb_o && hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Count consecutive matching word periods, saturating at the lock count.
    always_ff @(posedge clk) begin
        if (!rst_n)              match_cnt_q <= '0;
        else if (stb_o && !match) match_cnt_q <= '0;
        else if (stb_o && match_cnt_q != CNT_W'(LOCK_CNT))
                                  match_cnt_q <= match_cnt_q + 1'b1;
    end

    always_comb aligned_o = (match_cnt_q == CNT_W'(LOCK_CNT));
    always_comb accept_o  = stb_o && match && (match_cnt_q >= CNT_W'(LOCK_CNT - 1));

    // Checker state: word periods seen since the last boundary change.
    logic [HOLD_W:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                         gap_q <= (HOLD_W+1)'(SETTLE);
        else if (ofs_o != $past(ofs_o))     gap_q <= '0;
        else if (stb_o && gap_q != (HOLD_W+1)'(SETTLE)) gap_q <= gap_q + 1'b1;
    end

    // R4: the offset only changes once SETTLE word periods have passed.
    assert_settle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (ofs_o != $past(ofs_o)) |-> ($past(gap_q) == (HOLD_W+1)'(SETTLE)));
    // R3: without a mismatching marker word the boundary holds still.
    assert_offset_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb_o && frame_word_i != PAT) |=> $stable(ofs_o));
    // R6: a mismatch clears lock at the end of the word period.
    assert_drop_on_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o && frame_word_i != PAT |=> !aligned_o);
    // R5: lock can only rise on a word strobe with a matching marker.
    assert_lock_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned_o) |-> $past(stb_o) && ($past(frame_word_i) == PAT));
endmodule

// File: rtl/adc_frame_deser.sv
`timescale 1ns/1ps
// adc_frame_deser
// Top of the multi-lane deserializer: one gearbox per data lane plus one
// for the marker line, all sharing the boundary offset chosen by the
// aligner. Lane words are packed lane 0 lowest and registered once per
// word period; the qualifier is raised only when locked.
// Assumes: all lanes share clk_bit and arrive with the same skew.
module adc_frame_deser
    import adc_deser_pkg::*;
#(
    parameter int unsigned LANES    = DEF_LANES,
    parameter int unsigned BITS     = DEF_BITS,
    parameter logic [BITS-1:0] FRAME_PAT = DEF_FRAME_PAT,
    parameter int unsigned SETTLE   = DEF_SETTLE,
    parameter int unsigned LOCK_CNT = DEF_LOCK
) (
    input  logic                  clk_bit,
    input  logic                  rst_n,
    input  logic [7:0]            lane_ser_i,
    input  logic                  frame_ser_i,
    output logic [63:0]           word_o,
    output logic                  word_valid_o,
    output logic                  aligned_o
);
    localparam int unsigned OFS_W  = $clog2(BITS);
    localparam int unsigned WORD_W = LANES * BITS;

    logic [LANES-1:0][BITS-1:0] lane_words;
    logic [BITS-1:0]            frame_word;
    logic [OFS_W-1:0]           ofs;
    logic                       stb;
    logic                       accept;
    logic [WORD_W-1:0]          word_q;
    logic                       valid_q;

    // One gearbox per data lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        adc_lane_gearbox #(.W(BITS)) gb_i (
            .clk    (clk_bit),
            .rst_n  (rst_n),
            .ser_i  (lane_ser_i[i]),
            .ofs_i  (ofs),
            .word_o (lane_words[i])
        );
    end

    // Marker line uses the same gearbox so its boundary tracks the data.
    adc_lane_gearbox #(.W(BITS)) gb_frame_i (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .ser_i  (frame_ser_i),
        .ofs_i  (ofs),
        .word_o (frame_word)
    );

    adc_frame_aligner #(
        .W        (BITS),
        .PAT      (FRAME_PAT),
        .SETTLE   (SETTLE),
        .LOCK_CNT (LOCK_CNT)
    ) aligner_i (
        .clk          (clk_bit),
        .rst_n        (rst_n),
        .frame_word_i (frame_word),
        .stb_o        (stb),
        .ofs_o        (ofs),
        .aligned_o    (aligned_o),
        .accept_o     (accept)
    );

    // Register the packed word each word period and qualify it when locked.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (stb) word_q <= lane_words;
            valid_q <= accept;
        end
    end

    always_comb word_o       = word_q;
    always_comb word_valid_o = valid_q;

    // R7: a qualified word only appears while locked.
    assert_valid_locked_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        word_valid_o |-> aligned_o);
    // R1: at most one qualified word per word period.
    assert_valid_spacing_R1: assert property (@(posedge clk_bit) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);
    // R8: reset leaves the outputs idle.
    assert_reset_idle_R8: assert property (@(posedge clk_bit)
        !rst_n |=> !aligned_o && !word_valid_o);
endmodule

// File: tb/adc_frame_deser_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver serialises a triangle ramp on all lanes and
// queues every sample it starts; the monitor matches qualified words against
// the queue, resynchronising after each loss of lock.
module adc_frame_deser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lane_ser = '0;
    logic        frame_ser = 1'b0;
    logic [63:0] word;
    logic        word_valid;
    logic        aligned;

    int checks = 0;
    int fails  = 0;
    int k_ofs  = 0;
    int corrupt_left = 0;
    int words_ok = 0;
    bit locked = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    adc_frame_deser dut_i (
        .clk_bit      (clk),
        .rst_n        (rst_n),
        .lane_ser_i   (lane_ser),
        .frame_ser_i  (frame_ser),
        .word_o       (word),
        .word_valid_o (word_valid),
        .aligned_o    (aligned)
    );

    function automatic logic [7:0] ramp(int s);
        int m = s % 510;
        int v = (m <= 255) ? m : 510 - m;
        return v[7:0];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one bit of the stream; queue samples as each one starts.
    task automatic put_bit(int g);
        int t = g + k_ofs;
        int j = t / 8;
        int p = t % 8;
        logic [7:0] v;
        if (p == 0)
            for (int i = 0; i < 8; i++) exp_q.push_back(ramp(8 * j + i));
        for (int i = 0; i < 8; i++) begin
            v = ramp(8 * j + i);
            lane_ser[i] = v[7 - p];
        end
        if (corrupt_left > 0) begin
            frame_ser = 1'b0;
            corrupt_left--;
        end else begin
            frame_ser = (p < 4);
        end
    endtask

    // Driver: one bit per clock edge, MSB of each sample first.
    task automatic drive(int ncyc);
        int g = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(posedge clk); #1.25; put_bit(g); g++;
            @(negedge clk); #1.25; put_bit(g); g++;
        end
    endtask

    function automatic bit word_matches();
        for (int i = 0; i < 8; i++)
            if (exp_q[i] != word[8*i +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    // Monitor: compare qualified words with the sample queue.
    always @(negedge clk) begin
        if (!rst_n) begin
            locked = 0;
            exp_q.delete();
        end else begin
            if (!aligned) locked = 0;
            if (word_valid) begin
                check(aligned, "R7", "valid without lock", aligned, 1);
                if (!locked) begin
                    while (exp_q.size() >= 8 && !word_matches()) void'(exp_q.pop_front());
                    check(exp_q.size() >= 8, "R2", "first word found in stream", word, 0);
                    if (exp_q.size() >= 8) begin
                        for (int i = 0; i < 8; i++) void'(exp_q.pop_front());
                        locked = 1;
                        words_ok++;
                    end
                end else begin
                    // R2 lane order and R7 continuity in one comparison.
                    logic [63:0] exp_w;
                    for (int i = 0; i < 8; i++) exp_w[8*i +: 8] = (exp_q.size() > i) ? exp_q[i] : 8'h00;
                    check(exp_q.size() >= 8 && word == exp_w, "R7", "consecutive word", word, exp_w);
                    for (int i = 0; i < 8 && exp_q.size() > 0; i++) void'(exp_q.pop_front());
                    words_ok++;
                end
            end
        end
    end

    task automatic wait_aligned(string req, int limit);
        int n = 0;
        while (!aligned && n < limit) begin @(negedge clk); n++; end
        check(aligned, req, "lock within bound", n, limit);
    endtask

    // Alignment timing and disturbance checks, run beside the driver.
    task automatic observe(bit disturb);
        repeat (60) @(negedge clk);
        check(!aligned, "R5", "no lock before 16 words", aligned, 0);
        wait_aligned("R9", 320 - 60);
        if (disturb) begin
            repeat (100) @(negedge clk);
            check(aligned, "R6", "locked before disturbance", aligned, 1);
            corrupt_left = 8;
            begin
                int n = 0;
                while (aligned && n < 24) begin @(negedge clk); n++; end
                check(!aligned, "R6", "lock cleared by mismatch", aligned, 0);
                check(!word_valid, "R7", "no valid after mismatch", word_valid, 0);
            end
            wait_aligned("R3", 320);
        end
    endtask

    initial begin
        for (int r = 0; r < 10; r++) begin
            k_ofs = (r < 8) ? r : int'($urandom_range(7, 0));
            corrupt_left = 0;
            rst_n = 1'b0;
            lane_ser = '0;
            frame_ser = 1'b0;
            repeat (4) @(posedge clk);
            @(negedge clk);
            check(!aligned && !word_valid, "R8", "outputs idle in reset",
                  {aligned, word_valid}, 0);
            @(posedge clk); #1.25; rst_n = 1'b1;
            words_ok = 0;
            fork
                drive(2000);
                observe(r == 3 || r == 9);
            join
            check(words_ok > 250, "R1", "word rate over run", words_ok, 250);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule